// File: doc/BRIEF.md
# Non-Volatile Array Self-Test Sequencer

This block is a built-in self-test engine for a one-time-programmable memory array that is divided into three address spaces: a main space, a boot space and a redundancy space. A single-cycle start pulse and a two-bit space-select code launch a test. The engine then reads every word of the selected spaces twice. The first pass uses a stress read mode and the second pass uses a normal clean-array read. An unprogrammed array must read as all zeros, so any non-zero word counts as a failure.

The array sits behind a plain synchronous read port with one cycle of latency. The engine drives the read enable, the word address and a stress-mode flag, and it inspects the data that returns on the following cycle. While the test runs, the engine raises a busy flag. When the test completes, it raises a done flag. It also keeps a sticky global fail flag. Encoded fields report the phase and the space of the first failure, a two-bit code reports that non-zero data was seen, and a 13-bit field holds the address of the most recent failing word. The test does not stop at the first failure, so the last failing address always reflects the whole run.

Top module: `nvm_selftest`

## Requirements
- R1: After reset, busy, done, failAny, all codes, failAddr and memRdEn are 0. busy rises on the clock edge that samples start in idle. done rises on the edge where busy falls. busy and done are never 1 together.
- R2: spaceSel selects the spaces to test: 0 = main only, 1 = boot only, 2 = redundancy only, 3 = all three. A space that is not selected is never read.
- R3: The stress phase (memStress=1) reads every selected word once. The clean phase (memStress=0) then reads every selected word once more. Within each phase the spaces are visited in the order main, boot, redundancy. busy stays high for exactly 2*W+1 cycles, where W is the number of selected words.
- R4: Every word is expected to read as zero. failAny becomes 1 when any checked word is non-zero, and it stays 1 until the next accepted start.
- R5: phaseCode holds the phase of the first failure: 0 = pass, 1 = stress phase, 2 = clean phase. The value 3 never appears.
- R6: spaceCode holds the space of the first failure: 0 = pass, 1 = main, 2 = boot, 3 = redundancy.
- R7: dataCode is 1 once any word has read back non-zero, and 0 otherwise.
- R8: The test continues after a failure. failAddr (13 bits) takes the address of each failing word, so at completion it holds the last failing address. It does not change while the engine is idle.
- R9: A start pulse while busy is ignored. The running test, its length and its results are unchanged.
- R10: An accepted start clears done, failAny, phaseCode, spaceCode, dataCode and failAddr on the same edge that raises busy.
- R11: Read data is taken from memRdData exactly one cycle after the cycle in which memRdEn and memAddr were presented.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| start | input | 1 | Start pulse, accepted only when idle |
| spaceSel | input | 2 | Space-select code (see R2) |
| memRdEn | output | 1 | Array read enable |
| memAddr | output | ADDR_W | Array word address |
| memStress | output | 1 | 1 while reading in stress mode |
| memRdData | input | DATA_W | Array read data, one cycle after memRdEn |
| busy | output | 1 | Test running |
| done | output | 1 | Test finished |
| failAny | output | 1 | Sticky global fail flag |
| phaseCode | output | 2 | Phase of the first failure |
| spaceCode | output | 2 | Space of the first failure |
| dataCode | output | 2 | 1 when non-zero data was seen |
| failAddr | output | ADDR_W | Address of the last failing word |

## Verification
The bench builds the engine with tiny spaces: four main words at address 0, three boot words at 16 and two redundancy words at 32. With these sizes a full all-space run takes only 19 busy cycles, and every space boundary and phase turnover can be reached by a short directed vector. The bench memory model can inject a fault that appears only in stress mode, only in clean mode, or in both. This makes it possible to tell the first-failure codes apart from the last-failure address, and to confirm that unselected spaces are never touched.

// File: rtl/nvm_bist_pkg.sv
package nvm_bist_pkg;

  // Space codes double as the reported first-failure space encoding.
  typedef enum logic [1:0] {
    SP_NONE = 2'd0,
    SP_MAIN = 2'd1,
    SP_BOOT = 2'd2,
    SP_RED  = 2'd3
  } space_e;

  // Phase codes double as the reported first-failure phase encoding.
  typedef enum logic [1:0] {
    PH_PASS   = 2'd0,
    PH_STRESS = 2'd1,
    PH_CLEAN  = 2'd2,
    PH_RSVD   = 2'd3
  } phase_e;

  typedef enum logic [1:0] {
    ST_IDLE  = 2'd0,
    ST_RUN   = 2'd1,
    ST_DRAIN = 2'd2
  } state_e;

  // Strobes from the sequencer to the checking datapath.
  typedef struct packed {
    logic   clear;   // accepted start: wipe status
    logic   issue;   // a read is presented this cycle
    logic   stress;  // current phase is stress
    space_e space;   // space being read
  } bist_stb_t;

endpackage

// File: rtl/nvm_bist_ctrl.sv
module nvm_bist_ctrl
  import nvm_bist_pkg::*;
#(
  parameter int ADDR_W     = 13,
  parameter int MAIN_BASE  = 0,
  parameter int MAIN_WORDS = 4096,
  parameter int BOOT_BASE  = 4096,
  parameter int BOOT_WORDS = 2048,
  parameter int RED_BASE   = 6144,
  parameter int RED_WORDS  = 64
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              start,
  input  logic [1:0]        spaceSel,
  output bist_stb_t         stb,
  output logic [ADDR_W-1:0] rdAddr,
  output logic              busy,
  output logic              done
);

  localparam int MAX_AB = (MAIN_WORDS > BOOT_WORDS) ? MAIN_WORDS : BOOT_WORDS;
  localparam int MAX_W  = (MAX_AB > RED_WORDS) ? MAX_AB : RED_WORDS;
  localparam int OFS_W  = (MAX_W > 1) ? $clog2(MAX_W) : 1;

  function automatic logic [ADDR_W-1:0] baseOf(space_e s);
    case (s)
      SP_MAIN: baseOf = ADDR_W'(MAIN_BASE);
      SP_BOOT: baseOf = ADDR_W'(BOOT_BASE);
      SP_RED:  baseOf = ADDR_W'(RED_BASE);
      default: baseOf = '0;
    endcase
  endfunction

  function automatic logic [OFS_W-1:0] lastOfsOf(space_e s);
    case (s)
      SP_MAIN: lastOfsOf = OFS_W'(MAIN_WORDS - 1);
      SP_BOOT: lastOfsOf = OFS_W'(BOOT_WORDS - 1);
      SP_RED:  lastOfsOf = OFS_W'(RED_WORDS - 1);
      default: lastOfsOf = '0;
    endcase
  endfunction

  state_e           state;
  logic             stressPh;
  space_e           curSp;
  space_e           firstSp;
  space_e           lastSp;
  logic [OFS_W-1:0] ofs;
  logic             doneR;

  space_e selFirst;
  space_e selLast;
  logic   atLastWord;
  logic   accept;

  always_comb begin
    if (spaceSel == 2'd3) begin
      selFirst = SP_MAIN;
      selLast  = SP_RED;
    end else begin
      selFirst = space_e'(spaceSel + 2'd1);
      selLast  = space_e'(spaceSel + 2'd1);
    end
  end

  assign atLastWord = (ofs == lastOfsOf(curSp));
  assign accept     = (state == ST_IDLE) && start;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      state    <= ST_IDLE;
      stressPh <= 1'b0;
      curSp    <= SP_NONE;
      firstSp  <= SP_NONE;
      lastSp   <= SP_NONE;
      ofs      <= '0;
      doneR    <= 1'b0;
    end else begin
      case (state)
        ST_IDLE: begin
          if (start) begin
            state    <= ST_RUN;
            stressPh <= 1'b1;
            curSp    <= selFirst;
            firstSp  <= selFirst;
            lastSp   <= selLast;
            ofs      <= '0;
            doneR    <= 1'b0;
          end
        end
        ST_RUN: begin
          if (atLastWord) begin
            ofs <= '0;
            if (curSp == lastSp) begin
              if (stressPh) begin
                stressPh <= 1'b0;
                curSp    <= firstSp;
              end else begin
                state <= ST_DRAIN;
              end
            end else begin
              curSp <= space_e'(curSp + 2'd1);
            end
          end else begin
            ofs <= ofs + 1'b1;
          end
        end
        ST_DRAIN: begin
          state <= ST_IDLE;
          doneR <= 1'b1;
        end
        default: state <= ST_IDLE;
      endcase
    end
  end

  always_comb begin
    stb.clear  = accept;
    stb.issue  = (state == ST_RUN);
    stb.stress = stressPh;
    stb.space  = curSp;
  end

  assign rdAddr = baseOf(curSp) + ADDR_W'(ofs);
  assign busy   = (state != ST_IDLE);
  assign done   = doneR;

endmodule

// File: rtl/nvm_bist_dp.sv
module nvm_bist_dp
  import nvm_bist_pkg::*;
#(
  parameter int ADDR_W = 13,
  parameter int DATA_W = 32
) (
  input  logic              clk,
  input  logic              rstN,
  input  bist_stb_t         stb,
  input  logic [ADDR_W-1:0] rdAddr,
  input  logic [DATA_W-1:0] rdData,
  output logic              failAny,
  output logic [1:0]        phaseCode,
  output logic [1:0]        spaceCode,
  output logic [1:0]        dataCode,
  output logic [ADDR_W-1:0] failAddr
);

  // Tag of the read in flight: its data returns one cycle later.
  logic              tagValid;
  logic              tagStress;
  space_e            tagSpace;
  logic [ADDR_W-1:0] tagAddr;

  logic              failR;
  phase_e            phaseR;
  space_e            spaceR;
  logic [1:0]        dataR;
  logic [ADDR_W-1:0] addrR;

  logic hit;
  assign hit = tagValid && (|rdData);

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      tagValid  <= 1'b0;
      tagStress <= 1'b0;
      tagSpace  <= SP_NONE;
      tagAddr   <= '0;
    end else begin
      tagValid  <= stb.issue;
      tagStress <= stb.stress;
      tagSpace  <= stb.space;
      tagAddr   <= rdAddr;
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      failR  <= 1'b0;
      phaseR <= PH_PASS;
      spaceR <= SP_NONE;
      dataR  <= 2'd0;
      addrR  <= '0;
    end else if (stb.clear) begin
      failR  <= 1'b0;
      phaseR <= PH_PASS;
      spaceR <= SP_NONE;
      dataR  <= 2'd0;
      addrR  <= '0;
    end else if (hit) begin
      failR <= 1'b1;
      dataR <= 2'd1;
      addrR <= tagAddr;
      if (!failR) begin
        phaseR <= tagStress ? PH_STRESS : PH_CLEAN;
        spaceR <= tagSpace;
      end
    end
  end

  assign failAny   = failR;
  assign phaseCode = phaseR;
  assign spaceCode = spaceR;
  assign dataCode  = dataR;
  assign failAddr  = addrR;

endmodule

// File: rtl/nvm_selftest.sv
module nvm_selftest
  import nvm_bist_pkg::*;
#(
  parameter int ADDR_W     = 13,
  parameter int DATA_W     = 32,
  parameter int MAIN_BASE  = 0,
  parameter int MAIN_WORDS = 4096,
  parameter int BOOT_BASE  = 4096,
  parameter int BOOT_WORDS = 2048,
  parameter int RED_BASE   = 6144,
  parameter int RED_WORDS  = 64
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              start,
  input  logic [1:0]        spaceSel,
  output logic              memRdEn,
  output logic [ADDR_W-1:0] memAddr,
  output logic              memStress,
  input  logic [DATA_W-1:0] memRdData,
  output logic              busy,
  output logic              done,
  output logic              failAny,
  output logic [1:0]        phaseCode,
  output logic [1:0]        spaceCode,
  output logic [1:0]        dataCode,
  output logic [ADDR_W-1:0] failAddr
);

  bist_stb_t         stb;
  logic [ADDR_W-1:0] rdAddr;

  nvm_bist_ctrl #(
    .ADDR_W(ADDR_W), .MAIN_BASE(MAIN_BASE), .MAIN_WORDS(MAIN_WORDS),
    .BOOT_BASE(BOOT_BASE), .BOOT_WORDS(BOOT_WORDS),
    .RED_BASE(RED_BASE), .RED_WORDS(RED_WORDS)
  ) u_ctrl (
    .clk(clk), .rstN(rstN), .start(start), .spaceSel(spaceSel),
    .stb(stb), .rdAddr(rdAddr), .busy(busy), .done(done)
  );

  nvm_bist_dp #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_dp (
    .clk(clk), .rstN(rstN), .stb(stb), .rdAddr(rdAddr), .rdData(memRdData),
    .failAny(failAny), .phaseCode(phaseCode), .spaceCode(spaceCode),
    .dataCode(dataCode), .failAddr(failAddr)
  );

  assign memRdEn   = stb.issue;
  assign memAddr   = rdAddr;
  assign memStress = stb.issue && stb.stress;

endmodule

// File: rtl/nvm_bist_chk.sv
module nvm_bist_chk #(
  parameter int ADDR_W = 13
) (
  input logic              clk,
  input logic              rstN,
  input logic              start,
  input logic              memRdEn,
  input logic              memStress,
  input logic              busy,
  input logic              done,
  input logic              failAny,
  input logic [1:0]        phaseCode,
  input logic [1:0]        spaceCode,
  input logic [1:0]        dataCode,
  input logic [ADDR_W-1:0] failAddr
);

  a_r1_busy_done_excl: assert property (@(posedge clk) disable iff (!rstN)
    !(busy && done));

  a_r2_read_only_busy: assert property (@(posedge clk) disable iff (!rstN)
    memRdEn |-> busy);

  a_r3_clean_after_stress: assert property (@(posedge clk) disable iff (!rstN)
    $past(memRdEn) && !$past(memStress) && memRdEn |-> !memStress);

  a_r4_fail_sticky: assert property (@(posedge clk) disable iff (!rstN)
    busy && $past(busy) && $past(failAny) |-> failAny);

  a_r5_phase_legal: assert property (@(posedge clk) disable iff (!rstN)
    phaseCode != 2'd3);

  a_r6_space_iff_fail: assert property (@(posedge clk) disable iff (!rstN)
    (spaceCode != 2'd0) == failAny);

  a_r7_data_code: assert property (@(posedge clk) disable iff (!rstN)
    dataCode == {1'b0, failAny});

  a_r8_addr_hold_idle: assert property (@(posedge clk) disable iff (!rstN)
    !busy && !$past(busy) |-> $stable(failAddr));

  a_r9_start_ignored: assert property (@(posedge clk) disable iff (!rstN)
    $past(busy && start) && $past(failAny) |-> failAny);

endmodule

bind nvm_selftest nvm_bist_chk #(.ADDR_W(ADDR_W)) u_chk (
  .clk(clk), .rstN(rstN), .start(start), .memRdEn(memRdEn),
  .memStress(memStress), .busy(busy), .done(done), .failAny(failAny),
  .phaseCode(phaseCode), .spaceCode(spaceCode), .dataCode(dataCode),
  .failAddr(failAddr)
);

// File: tb/sim_nvm_selftest.sv
module sim_nvm_selftest;

  localparam int AW = 13;
  localparam int DW = 32;

  // Vector: select, stress-only fault addr, clean-only fault addr
  // (63 = no fault), expected phase, space, last addr, fail, busy cycles.
  typedef struct packed {
    logic [1:0]  sel;
    logic [5:0]  sf;
    logic [5:0]  cf;
    logic [1:0]  ePh;
    logic [1:0]  eSp;
    logic [12:0] eAddr;
    logic        eFail;
    logic [7:0]  eBusy;
  } vec_t;

  localparam int NV = 8;
  localparam vec_t VEC [NV] = '{
    '{2'd3, 6'd63, 6'd63, 2'd0, 2'd0, 13'd0,  1'b0, 8'd19},
    '{2'd0, 6'd2,  6'd63, 2'd1, 2'd1, 13'd2,  1'b1, 8'd9},
    '{2'd1, 6'd63, 6'd17, 2'd2, 2'd2, 13'd17, 1'b1, 8'd7},
    '{2'd2, 6'd33, 6'd33, 2'd1, 2'd3, 13'd33, 1'b1, 8'd5},
    '{2'd3, 6'd32, 6'd1,  2'd1, 2'd3, 13'd1,  1'b1, 8'd19},
    '{2'd3, 6'd63, 6'd18, 2'd2, 2'd2, 13'd18, 1'b1, 8'd19},
    '{2'd0, 6'd17, 6'd63, 2'd0, 2'd0, 13'd0,  1'b0, 8'd9},
    '{2'd3, 6'd0,  6'd33, 2'd1, 2'd1, 13'd33, 1'b1, 8'd19}
  };

  logic          clk = 1'b0;
  logic          rstN = 1'b0;
  logic          start = 1'b0;
  logic [1:0]    spaceSel = 2'd0;
  logic          memRdEn, memStress;
  logic [AW-1:0] memAddr;
  logic [DW-1:0] memRdData = '0;
  logic          busy, done, failAny;
  logic [1:0]    phaseCode, spaceCode, dataCode;
  logic [AW-1:0] failAddr;

  logic [5:0] sfA = 6'd63;
  logic [5:0] cfA = 6'd63;
  logic [1:0] runSel = 2'd0;
  int rdCnt = 0, stCnt = 0, badCnt = 0;
  int checks = 0, errors = 0, cyc = 0;

  always #4 clk = ~clk;

  nvm_selftest #(
    .ADDR_W(AW), .DATA_W(DW), .MAIN_BASE(0), .MAIN_WORDS(4),
    .BOOT_BASE(16), .BOOT_WORDS(3), .RED_BASE(32), .RED_WORDS(2)
  ) u0 (.*);

  function automatic bit inSel(logic [1:0] s, logic [AW-1:0] a);
    bit m = (a <= 3);
    bit b = (a >= 16 && a <= 18);
    bit r = (a >= 32 && a <= 33);
    case (s)
      2'd0: inSel = m;
      2'd1: inSel = b;
      2'd2: inSel = r;
      default: inSel = m || b || r;
    endcase
  endfunction

  // Array model: one-cycle read latency, faults seen only in one read mode.
  always @(posedge clk) begin
    cyc <= cyc + 1;
    if (memRdEn) begin
      rdCnt <= rdCnt + 1;
      if (memStress) stCnt <= stCnt + 1;
      if (!inSel(runSel, memAddr)) badCnt <= badCnt + 1;
      if ((memStress && memAddr == AW'(sfA)) || (!memStress && memAddr == AW'(cfA)))
        memRdData <= 32'h0000_0100;
      else
        memRdData <= '0;
    end
  end

  task automatic chk(string req, int act, int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s actual %0d expected %0d", req, act, exp);
    end
  endtask

  always @(posedge clk) begin
    if (cyc > 150000) begin
      errors++;
      $display("FAIL watchdog actual %0d expected %0d", cyc, 150000);
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  // One run; optionally pulse start (with select 0) mid-run at busy count pulseAt.
  task automatic runTest(vec_t v, int pulseAt, string tag);
    int cnt = 0;
    int rd0, st0, bad0;
    int w;
    @(negedge clk);
    sfA = v.sf; cfA = v.cf; runSel = v.sel;
    spaceSel = v.sel; start = 1'b1;
    rd0 = rdCnt; st0 = stCnt; bad0 = badCnt;
    @(negedge clk);
    start = 1'b0;
    // R10: status wiped on the start edge
    chk({tag, " R10 done clear"}, done, 0);
    chk({tag, " R10 fail clear"}, failAny, 0);
    chk({tag, " R10 addr clear"}, failAddr, 0);
    while (busy && cnt < 1000) begin
      cnt++;
      if (cnt == pulseAt) begin start = 1'b1; spaceSel = 2'd0; end
      else start = 1'b0;
      @(negedge clk);
    end
    start = 1'b0;
    w = (v.eBusy - 1) / 2;
    chk({tag, " R3 busy cycles"}, cnt, v.eBusy);
    chk({tag, " R1 done"}, done, 1);
    chk({tag, " R3 reads"}, rdCnt - rd0, 2 * w);
    chk({tag, " R3 stress reads"}, stCnt - st0, w);
    chk({tag, " R2 unselected reads"}, badCnt - bad0, 0);
    chk({tag, " R4 fail"}, failAny, v.eFail);
    chk({tag, " R5 phase"}, phaseCode, v.ePh);
    chk({tag, " R6 space"}, spaceCode, v.eSp);
    chk({tag, " R7 data code"}, dataCode, v.eFail ? 1 : 0);
    chk({tag, " R8 R11 last addr"}, failAddr, v.eAddr);
  endtask

  initial begin
    vec_t pv;
    int a0;
    #3;
    // R1: reset state
    chk("R1 rst busy", busy, 0);
    chk("R1 rst done", done, 0);
    chk("R1 rst fail", failAny, 0);
    chk("R1 rst rden", memRdEn, 0);
    chk("R1 rst codes", {phaseCode, spaceCode, dataCode}, 0);
    chk("R1 rst addr", failAddr, 0);
    repeat (2) @(negedge clk);
    rstN = 1'b1;

    for (int i = 0; i < NV; i++) runTest(VEC[i], 0, $sformatf("vec%0d", i));

    // R9: start pulse while busy is ignored
    pv = '{2'd3, 6'd63, 6'd1, 2'd2, 2'd1, 13'd1, 1'b1, 8'd19};
    runTest(pv, 5, "R9 mid-run start");

    // R8: idle state holds failAddr across several cycles
    a0 = failAddr;
    repeat (5) @(negedge clk);
    chk("R8 idle hold", failAddr, a0);
    chk("R1 idle done held", done, 1);

    // R10: passing run after a failing one ends clean
    runTest(VEC[0], 0, "R10 clean rerun");

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule